// File: doc/BRIEF.md
# Dual-Channel DAC Serial Command Controller

This block is the digital front end of a two-channel 10-bit converter. A host sends 16-bit command words over a three-wire serial link: an active-low frame select that also acts as the load strobe, a serial clock, and a data line. While the frame select is low, each rising serial-clock edge shifts one bit into a word register. When the frame select rises, the 4-bit control code at the head of the last 16 bits shifted is decoded and carried out.

Each channel keeps a staging (input) register and a converter (DAC) register, both 10 bits wide. Commands can stage a value for one channel, stage the same value for both, copy both staging registers into the converter registers together, or change the power state. A sleep state holds every register and raises a flag that puts the analog outputs into high impedance; staging writes are allowed during sleep without leaving it. Frames with fewer than 16 clock edges are dropped and flagged with a one-cycle error pulse.

The three serial pins are brought into the system clock domain through two flip-flops each, and edges are found there, so the serial clock must run at no more than one quarter of the system clock rate. The serial link carries no back-pressure: the host paces the frames, and the block accepts every complete frame in the cycle its load edge is detected.

Top module: `dac_cmd_ctrl`

## Requirements
- R1: After reset both staging registers and both converter registers hold zero, the part is awake (`out_hiz` low) and `frame_err` is low.
- R2: A bit on `sdi` is taken only on a rising `sck` edge while `cs_ld_n` is low; `sck` edges while `cs_ld_n` is high are not counted and do not enter the word. Bits arrive MSB first: control code in word bits 15..12, data in bits 11..2, bits 1..0 ignored.
- R3: The command executes on the rising edge of `cs_ld_n` and uses the last 16 bits shifted in that frame, even when more than 16 edges arrived.
- R4: A frame with fewer than 16 shift edges is discarded: no register or power state changes, and `frame_err` is high for exactly one system clock cycle.
- R5: Code 0001 writes the data to staging register A and code 0010 writes staging register B; neither changes a converter output or the power state, including while asleep.
- R6: Code 1000 copies both staging registers into both converter registers and wakes the part.
- R7: Code 1001 writes staging A with the data and then copies new A and existing B to the converter registers and wakes; code 1010 does the same with B written and existing A.
- R8: Code 1101 wakes the part with all registers unchanged; code 1110 sets `out_hiz`, ignores the data field and keeps all register contents.
- R9: Code 1111 writes the data into both staging registers and both converter registers and wakes the part.
- R10: Code 0000 and the reserved codes 0011 to 0111, 1011 and 1100 leave all registers and the power state unchanged.
- R11: A converter register changes only in a step that updates both channels together, and never while `out_hiz` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_ld_n | input | 1 | Serial frame select, low during shifting; rising edge loads |
| sck | input | 1 | Serial clock, at most a quarter of `clk` rate |
| sdi | input | 1 | Serial data, MSB first |
| dac_a | output | 10 | Converter register of channel A |
| dac_b | output | 10 | Converter register of channel B |
| out_hiz | output | 1 | Sleep state: analog outputs in high impedance |
| frame_err | output | 1 | One-cycle pulse for a short frame |

## Verification
The functions that meet in one cycle are the staging write and the converter update: codes 1001, 1010 and 1111 write a staging register and copy it onward at the same load edge, so the converter must receive the new data, not the stale staging value. The bench provokes this by staging a known value in one channel, then sending the combined code with a different value for the other channel, and judges both outputs after the load. A second meeting point is wake with update after staging during sleep: staging writes are sent while `out_hiz` is high and the bench checks that the flag stays high and outputs stay frozen until the combined command drops the flag and moves both outputs in the same cycle.

// File: rtl/dacc_pkg.sv
package dacc_pkg;
  localparam int CODE_W = 4;
  localparam int DATA_W = 10;
  localparam int PAD_W  = 2;
  localparam int WORD_W = CODE_W + DATA_W + PAD_W;
  localparam int NCH    = 2;

  typedef enum logic [CODE_W-1:0] {
    OP_NOP     = 4'b0000,
    OP_STG_A   = 4'b0001,
    OP_STG_B   = 4'b0010,
    OP_UPD     = 4'b1000,
    OP_STG_A_U = 4'b1001,
    OP_STG_B_U = 4'b1010,
    OP_WAKE    = 4'b1101,
    OP_SLEEP   = 4'b1110,
    OP_STG_ALL = 4'b1111
  } dacc_op_e;

  typedef struct packed {
    logic [NCH-1:0] stage;
    logic           upd;
    logic           wake;
    logic           sleep;
  } dacc_act_t;
endpackage

// File: rtl/dacc_sync.sv
module dacc_sync #(
  parameter int              WIDTH   = 3,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= RST_VAL;
        else if (s == 0) chain[s] <= d_in;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/dacc_shifter.sv
module dacc_shifter
  import dacc_pkg::*;
#(
  parameter int WIDTH = WORD_W,
  parameter int KEEP  = CODE_W + DATA_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shift_en,
  input  logic            bit_in,
  input  logic            clr,
  output logic [KEEP-1:0] head,
  output logic            full
);
  localparam int CNT_W = $clog2(WIDTH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WIDTH);

  logic [WIDTH-1:0] sreg;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '0;
    end else if (shift_en) begin
      sreg <= {sreg[WIDTH-2:0], bit_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (shift_en && (cnt != CNT_MAX)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign head = sreg[WIDTH-1 -: KEEP];
  assign full = (cnt == CNT_MAX);
endmodule

// File: rtl/dacc_decode.sv
module dacc_decode
  import dacc_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output dacc_act_t         act
);
  always_comb begin
    act = '0;
    unique case (code)
      OP_STG_A:   act.stage = 2'b01;
      OP_STG_B:   act.stage = 2'b10;
      OP_UPD:     begin act.upd = 1'b1; act.wake = 1'b1; end
      OP_STG_A_U: begin act.stage = 2'b01; act.upd = 1'b1; act.wake = 1'b1; end
      OP_STG_B_U: begin act.stage = 2'b10; act.upd = 1'b1; act.wake = 1'b1; end
      OP_WAKE:    act.wake = 1'b1;
      OP_SLEEP:   act.sleep = 1'b1;
      OP_STG_ALL: begin act.stage = 2'b11; act.upd = 1'b1; act.wake = 1'b1; end
      default:    act = '0;
    endcase
  end
endmodule

// File: rtl/dacc_regs.sv
module dacc_regs
  import dacc_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CH = NCH
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  exec,
  input  dacc_act_t             act,
  input  logic [DW-1:0]         data,
  output logic [CH-1:0][DW-1:0] dac_q,
  output logic                  sleep_q
);
  logic [CH-1:0][DW-1:0] stg_q;

  generate
    for (genvar ch = 0; ch < CH; ch++) begin : g_chan
      logic [DW-1:0] stg_next;
      assign stg_next = act.stage[ch] ? data : stg_q[ch];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stg_q[ch] <= '0;
          dac_q[ch] <= '0;
        end else if (exec) begin
          stg_q[ch] <= stg_next;
          if (act.upd) dac_q[ch] <= stg_next;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_q <= 1'b0;
    end else if (exec) begin
      if (act.sleep) sleep_q <= 1'b1;
      else if (act.wake) sleep_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dac_cmd_ctrl.sv
module dac_cmd_ctrl
  import dacc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_ld_n,
  input  logic              sck,
  input  logic              sdi,
  output logic [DATA_W-1:0] dac_a,
  output logic [DATA_W-1:0] dac_b,
  output logic              out_hiz,
  output logic              frame_err
);
  localparam int KEEP_W = CODE_W + DATA_W;

  // pin order in the sync vector: {cs, sck, sdi}; cs idles high
  logic [2:0] pin_s;
  logic       cs_prev, sck_prev;

  dacc_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({cs_ld_n, sck, sdi}),
    .d_out (pin_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev  <= 1'b1;
      sck_prev <= 1'b0;
    end else begin
      cs_prev  <= pin_s[2];
      sck_prev <= pin_s[1];
    end
  end

  logic cs_rise, sck_rise, shift_en;
  assign cs_rise  = pin_s[2] & ~cs_prev;
  assign sck_rise = pin_s[1] & ~sck_prev;
  assign shift_en = sck_rise & ~pin_s[2];

  logic [KEEP_W-1:0] head;
  logic              full;

  dacc_shifter #(.WIDTH(WORD_W), .KEEP(KEEP_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .bit_in   (pin_s[0]),
    .clr      (cs_rise),
    .head     (head),
    .full     (full)
  );

  dacc_act_t act;
  dacc_decode u_dec (
    .code (head[KEEP_W-1 -: CODE_W]),
    .act  (act)
  );

  logic exec_fire, upd_fire;
  assign exec_fire = cs_rise & full;
  assign upd_fire  = exec_fire & act.upd;

  logic [NCH-1:0][DATA_W-1:0] dac_q;

  dacc_regs #(.DW(DATA_W), .CH(NCH)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .exec    (exec_fire),
    .act     (act),
    .data    (head[DATA_W-1:0]),
    .dac_q   (dac_q),
    .sleep_q (out_hiz)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_err <= 1'b0;
    else        frame_err <= cs_rise & ~full;
  end

  assign dac_a = dac_q[0];
  assign dac_b = dac_q[1];
endmodule

// File: rtl/dacc_chk.sv
module dacc_chk
  import dacc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] dac_a,
  input logic [DATA_W-1:0] dac_b,
  input logic              out_hiz,
  input logic              frame_err,
  input logic              upd_fire
);
  AST_DAC_ONLY_ON_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(dac_a) || !$stable(dac_b)) |-> $past(upd_fire)); // R11

  AST_SLEEP_FREEZES_DAC: assert property (@(posedge clk) disable iff (!rst_n)
    out_hiz |-> ($stable(dac_a) && $stable(dac_b))); // R8

  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err); // R4

  AST_ERR_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> ($stable(dac_a) && $stable(dac_b) && $stable(out_hiz))); // R4

  AST_UPDATE_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(upd_fire) |-> !out_hiz); // R6
endmodule

bind dac_cmd_ctrl dacc_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dac_a     (dac_a),
  .dac_b     (dac_b),
  .out_hiz   (out_hiz),
  .frame_err (frame_err),
  .upd_fire  (upd_fire)
);

// File: tb/sim_dac_cmd_ctrl.sv
module sim_dac_cmd_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_ld_n = 1'b1;
  logic sck = 1'b0;
  logic sdi = 1'b0;
  logic [9:0] dac_a, dac_b;
  logic out_hiz, frame_err;

  int n_cmp = 0;
  int n_bad = 0;
  bit err_seen;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dac_cmd_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cs_ld_n(cs_ld_n), .sck(sck), .sdi(sdi),
    .dac_a(dac_a), .dac_b(dac_b), .out_hiz(out_hiz), .frame_err(frame_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input int n, input logic [31:0] w);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = w[i];
      sck = 1'b0;
      wait_clk(3);
      sck = 1'b1;
      wait_clk(3);
    end
    sck = 1'b0;
    wait_clk(3);
  endtask

  // frame: cs low, n bits, cs high, then watch for the error pulse
  task automatic frame(input int n, input logic [31:0] w);
    err_seen = 1'b0;
    cs_ld_n = 1'b0;
    wait_clk(3);
    shift_bits(n, w);
    cs_ld_n = 1'b1;
    for (int k = 0; k < 8; k++) begin
      wait_clk(1);
      if (frame_err) err_seen = 1'b1;
    end
  endtask

  function automatic logic [31:0] word16(input logic [3:0] c, input logic [9:0] d);
    return {16'h0, c, d, 2'b11};
  endfunction

  // vector: {req, code, data, exp_a, exp_b, exp_hiz}
  localparam int NV = 17;
  localparam logic [38:0] VEC [NV] = '{
    {4'd5,  4'b0001, 10'h155, 10'h000, 10'h000, 1'b0}, // R5 stage A
    {4'd5,  4'b0010, 10'h2AA, 10'h000, 10'h000, 1'b0}, // R5 stage B
    {4'd6,  4'b1000, 10'h3FF, 10'h155, 10'h2AA, 1'b0}, // R6 update both
    {4'd8,  4'b1110, 10'h3FF, 10'h155, 10'h2AA, 1'b1}, // R8 sleep
    {4'd5,  4'b0001, 10'h011, 10'h155, 10'h2AA, 1'b1}, // R5 stage in sleep
    {4'd7,  4'b1010, 10'h022, 10'h011, 10'h022, 1'b0}, // R7 stage B + update + wake
    {4'd7,  4'b1001, 10'h3FF, 10'h3FF, 10'h022, 1'b0}, // R7 stage A + update
    {4'd10, 4'b0011, 10'h000, 10'h3FF, 10'h022, 1'b0}, // R10 reserved
    {4'd10, 4'b0111, 10'h123, 10'h3FF, 10'h022, 1'b0}, // R10 reserved
    {4'd10, 4'b1011, 10'h123, 10'h3FF, 10'h022, 1'b0}, // R10 reserved
    {4'd10, 4'b1100, 10'h123, 10'h3FF, 10'h022, 1'b0}, // R10 reserved
    {4'd10, 4'b0000, 10'h123, 10'h3FF, 10'h022, 1'b0}, // R10 no-op
    {4'd8,  4'b1110, 10'h000, 10'h3FF, 10'h022, 1'b1}, // R8 sleep
    {4'd8,  4'b1101, 10'h155, 10'h3FF, 10'h022, 1'b0}, // R8 wake only
    {4'd9,  4'b1111, 10'h200, 10'h200, 10'h200, 1'b0}, // R9 same code both
    {4'd8,  4'b1110, 10'h001, 10'h200, 10'h200, 1'b1}, // R8 sleep again
    {4'd11, 4'b1000, 10'h000, 10'h200, 10'h200, 1'b0}  // R11 update wakes, both together
  };

  initial begin
    wait_clk(5);
    chk("R1 dac_a at reset", dac_a, 0);
    chk("R1 out_hiz at reset", out_hiz, 0);
    rst_n = 1'b1;
    wait_clk(5);
    chk("R1 dac_b after reset", dac_b, 0);
    chk("R1 frame_err after reset", frame_err, 0);

    for (int v = 0; v < NV; v++) begin
      logic [38:0] e;
      string tag;
      e = VEC[v];
      tag = $sformatf("R%0d vec%0d", e[38:35], v);
      frame(16, word16(e[34:31], e[30:21]));
      chk({tag, " dac_a"}, dac_a, e[20:11]);
      chk({tag, " dac_b"}, dac_b, e[10:1]);
      chk({tag, " out_hiz"}, out_hiz, e[0]);
      chk({tag, " no frame_err"}, err_seen, 0);
    end

    // R7 same cycle stage+update: stage B in sleep, then A-combined command
    frame(16, word16(4'b1110, 10'h0));
    frame(16, word16(4'b0010, 10'h0AB));
    chk("R5 sleep kept after stage", out_hiz, 1);
    chk("R11 frozen in sleep", dac_b, 10'h200);
    frame(16, word16(4'b1001, 10'h0CD));
    chk("R7 new A", dac_a, 10'h0CD);
    chk("R7 staged B", dac_b, 10'h0AB);
    chk("R7 woke", out_hiz, 0);

    // R4 short frame with a full-update code
    frame(10, {22'h0, 4'b1111, 6'h3F});
    chk("R4 error pulse", err_seen, 1);
    chk("R4 dac_a kept", dac_a, 10'h0CD);
    chk("R4 dac_b kept", dac_b, 10'h0AB);

    // R3 long frame: last 16 of 20 bits are 1111 0x3C3
    frame(20, {12'h0, 4'b1010, 4'b1111, 10'h3C3, 2'b00});
    chk("R3 last16 dac_a", dac_a, 10'h3C3);
    chk("R3 last16 dac_b", dac_b, 10'h3C3);
    chk("R3 no error", err_seen, 0);

    // R2 clock edges with frame select high are not counted
    sdi = 1'b1;
    shift_bits(20, 32'hFFFFF);
    frame(10, {22'h0, 4'b1000, 6'h0});
    chk("R2 idle edges ignored, short frame flagged", err_seen, 1);
    chk("R2 dac_a kept", dac_a, 10'h3C3);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R3 watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule